// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This unit resolves short PC-relative conditional branches for a simple in-order core. A compare operation does not produce flags. Instead it copies two 32-bit register values into a pair of holding registers. A later branch operation names one of ten relations, which can be signed, unsigned or equality. The unit tests that relation directly on the two held values and computes the next program counter. A taken branch goes to the address of the following instruction plus a sign-extended 10-bit halfword offset. A branch that is not taken falls through to the following instruction, which is two bytes on.

A small state machine records the outcome of each branch in the cycle after its strobe. It has four states. ST_IDLE means no branch was presented in the previous cycle. ST_TAKEN and ST_NOT_TAKEN report a resolved legal branch. ST_FAULT reports an illegal condition code. The state returns to ST_IDLE when no branch strobe is present. Otherwise it moves to ST_FAULT if the code is 10 to 15, to ST_TAKEN if the relation holds, and to ST_NOT_TAKEN if it does not. Transitions out of each state follow the same rule, so any state can reach any other in one cycle.

Top module: `bru_core`

## Requirements
- R1: After reset both held operands are zero, the state is ST_IDLE and `res_valid`, `res_taken` and `res_illegal` are low.
- R2: A cycle with `cmp_load` high stores `cmp_a` as operand A and `cmp_b` as operand B. Later branches use these values.
- R3: Condition codes are: 0 A==B, 1 A!=B, 2 A<B signed, 3 A>B signed, 4 A<B unsigned, 5 A>B unsigned, 6 A>=B signed, 7 A<=B signed, 8 A>=B unsigned, 9 A<=B unsigned. `res_taken` is high when the relation holds.
- R4: For a taken branch, `res_next_pc` = `cur_pc` + 2 + (sign-extended `br_offset` shifted left by one), modulo 2^32.
- R5: For a legal branch that is not taken, `res_next_pc` = `cur_pc` + 2.
- R6: Condition codes 10 to 15 raise `res_illegal`, keep `res_taken` low, and return `res_next_pc` equal to the `cur_pc` of the faulting branch.
- R7: When `cmp_load` and `br_req` are high in the same cycle, the branch is evaluated on the operands held before that cycle. The new operands take effect afterwards.
- R8: The result is registered. `res_valid` is high exactly in the cycle after a `br_req` cycle, and low otherwise.
- R9: `res_taken` and `res_illegal` are never high together, and both are low whenever `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_load | input | 1 | Capture strobe for the compare operands |
| cmp_a | input | 32 | Value for operand A |
| cmp_b | input | 32 | Value for operand B |
| br_req | input | 1 | Branch strobe |
| br_cond | input | 4 | Condition code (see R3, R6) |
| br_offset | input | 10 | Signed halfword branch displacement |
| cur_pc | input | 32 | Address of the branch instruction |
| res_valid | output | 1 | Branch result present this cycle |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Next program counter |
| res_illegal | output | 1 | Illegal condition code |

## Verification
A compare capture and a branch evaluation can both happen in one cycle. The bench forces this by raising `cmp_load` and `br_req` together, with new operands chosen so that the old and new pairs give opposite outcomes. The result must match a reference model that still holds the old pair. A following branch with the same condition must then match the new pair. Apart from this, the bench sweeps every condition code over a grid of operand pairs placed at the signed and unsigned boundaries. It also tests extreme offsets and PC values that wrap around.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAKEN,
        ST_NOT_TAKEN,
        ST_FAULT
    } bru_state_e;

    // Relation codes; numbering is decoded by the branch encoding.
    localparam logic [3:0] CC_EQ  = 4'd0;
    localparam logic [3:0] CC_NE  = 4'd1;
    localparam logic [3:0] CC_SLT = 4'd2;
    localparam logic [3:0] CC_SGT = 4'd3;
    localparam logic [3:0] CC_ULT = 4'd4;
    localparam logic [3:0] CC_UGT = 4'd5;
    localparam logic [3:0] CC_SGE = 4'd6;
    localparam logic [3:0] CC_SLE = 4'd7;
    localparam logic [3:0] CC_UGE = 4'd8;
    localparam logic [3:0] CC_ULE = 4'd9;
endpackage

// File: rtl/bru_operand_latch.sv
module bru_operand_latch #(
    parameter int DATA_W = 32,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [LANES-1:0][DATA_W-1:0]  d,
    output logic [LANES-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (load)
                q[g] <= d[g];
        end
    end
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [3:0]        cond,
    output logic              hit,
    output logic              legal
);
    logic eq, slt, ult;

    always_comb begin
        eq  = (opa == opb);
        slt = ($signed(opa) < $signed(opb));
        ult = (opa < opb);
        legal = 1'b1;
        case (cond)
            CC_EQ:   hit = eq;
            CC_NE:   hit = !eq;
            CC_SLT:  hit = slt;
            CC_SGT:  hit = !slt && !eq;
            CC_ULT:  hit = ult;
            CC_UGT:  hit = !ult && !eq;
            CC_SGE:  hit = !slt;
            CC_SLE:  hit = slt || eq;
            CC_UGE:  hit = !ult;
            CC_ULE:  hit = ult || eq;
            default: begin
                hit   = 1'b0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  jump_pc
);
    localparam int EXT_W = PC_W - OFF_W - 1;
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

    logic [PC_W-1:0] disp;

    always_comb begin
        disp    = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
        seq_pc  = pc + INSN_BYTES;
        jump_pc = seq_pc + disp;
    end
endmodule

// File: rtl/bru_core.sv
module bru_core
    import bru_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_load,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_req,
    input  logic [3:0]        br_cond,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [PC_W-1:0]   cur_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_next_pc,
    output logic              res_illegal
);
    localparam int LANES = 2;

    logic [LANES-1:0][DATA_W-1:0] held;
    logic [LANES-1:0][DATA_W-1:0] fresh;
    logic             hit, legal;
    logic [PC_W-1:0]  seq_pc, jump_pc;
    bru_state_e       state_q, state_d;

    assign fresh[0] = cmp_a;
    assign fresh[1] = cmp_b;

    bru_operand_latch #(.DATA_W(DATA_W), .LANES(LANES)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cmp_load),
        .d    (fresh),
        .q    (held)
    );

    bru_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .opa  (held[0]),
        .opb  (held[1]),
        .cond (br_cond),
        .hit  (hit),
        .legal(legal)
    );

    bru_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc     (cur_pc),
        .offset (br_offset),
        .seq_pc (seq_pc),
        .jump_pc(jump_pc)
    );

    // Next-state selection
    always_comb begin
        if (!br_req)
            state_d = ST_IDLE;
        else if (!legal)
            state_d = ST_FAULT;
        else if (hit)
            state_d = ST_TAKEN;
        else
            state_d = ST_NOT_TAKEN;
    end

    // State and PC registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            res_next_pc <= '0;
        end else begin
            state_q <= state_d;
            if (br_req) begin
                unique case (state_d)
                    ST_TAKEN:     res_next_pc <= jump_pc;
                    ST_NOT_TAKEN: res_next_pc <= seq_pc;
                    ST_FAULT:     res_next_pc <= cur_pc;
                    ST_IDLE:      res_next_pc <= res_next_pc;
                endcase
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        res_valid   = 1'b0;
        res_taken   = 1'b0;
        res_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_TAKEN:     begin res_valid = 1'b1; res_taken = 1'b1; end
            ST_NOT_TAKEN: res_valid = 1'b1;
            ST_FAULT:     begin res_valid = 1'b1; res_illegal = 1'b1; end
        endcase
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && held[0] == '0 && held[1] == '0));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_load |=> (held[0] == $past(cmp_a) && held[1] == $past(cmp_b)));

    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        br_req |=> res_valid);

    a_r8_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !br_req |=> !res_valid);

    a_r6_fault_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_cond > 4'd9) |=>
            (res_illegal && !res_taken && res_next_pc == $past(cur_pc)));

    a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_cond <= 4'd9) |=>
            (!res_illegal && (res_taken || res_next_pc == $past(cur_pc) + PC_W'(2))));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_taken && res_illegal) && (res_valid || (!res_taken && !res_illegal)));
endmodule

// File: tb/test_bru_core.sv
`timescale 1ns/1ps
module test_bru_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_load;
    logic [31:0] cmp_a, cmp_b;
    logic        br_req;
    logic [3:0]  br_cond;
    logic [9:0]  br_offset;
    logic [31:0] cur_pc;
    logic        res_valid, res_taken, res_illegal;
    logic [31:0] res_next_pc;

    int total = 0;
    int bad   = 0;
    logic [31:0] m_a = 0, m_b = 0;

    always #4 clk = ~clk;

    bru_core i_bru_core (
        .clk(clk), .rst_n(rst_n),
        .cmp_load(cmp_load), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_req(br_req), .br_cond(br_cond), .br_offset(br_offset),
        .cur_pc(cur_pc),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_next_pc(res_next_pc), .res_illegal(res_illegal)
    );

    function automatic logic relation(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, ua, ub;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
        case (c)
            4'd0: return ua == ub;
            4'd1: return ua != ub;
            4'd2: return sa < sb;
            4'd3: return sa > sb;
            4'd4: return ua < ub;
            4'd5: return ua > ub;
            4'd6: return sa >= sb;
            4'd7: return sa <= sb;
            4'd8: return ua >= ub;
            4'd9: return ua <= ub;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        cmp_load = 1'b1; cmp_a = a; cmp_b = b;
        @(negedge clk);
        cmp_load = 1'b0;
        m_a = a; m_b = b;
    endtask

    // Drive a branch; optionally a simultaneous compare (R7). Checks next cycle.
    task automatic do_br(input logic [3:0] c, input logic [9:0] off, input logic [31:0] pc,
                         input logic with_cmp, input logic [31:0] na, input logic [31:0] nb,
                         input string req);
        logic t, ill;
        logic [31:0] exp_pc, disp;
        ill  = (c > 4'd9);
        t    = relation(c, m_a, m_b);
        disp = {{21{off[9]}}, off, 1'b0};
        exp_pc = ill ? pc : (t ? pc + 32'd2 + disp : pc + 32'd2);
        br_req = 1'b1; br_cond = c; br_offset = off; cur_pc = pc;
        cmp_load = with_cmp; cmp_a = na; cmp_b = nb;
        @(negedge clk);
        br_req = 1'b0; cmp_load = 1'b0;
        if (with_cmp) begin m_a = na; m_b = nb; end
        chk({req, " R8 valid"}, {31'd0, res_valid}, 32'd1);
        chk({req, " R3 taken"}, {31'd0, res_taken}, {31'd0, t});
        chk({req, " R6 illegal"}, {31'd0, res_illegal}, {31'd0, ill});
        chk({req, " R4/R5 pc"}, res_next_pc, exp_pc);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_0005;
        rst_n = 1'b0; cmp_load = 0; cmp_a = 0; cmp_b = 0;
        br_req = 0; br_cond = 0; br_offset = 0; cur_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, outputs idle and operands zero
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 taken", {31'd0, res_taken}, 32'd0);
        do_br(4'd0, 10'd4, 32'h100, 0, 0, 0, "R1 zero operands eq");
        do_br(4'd1, 10'd4, 32'h100, 0, 0, 0, "R1 zero operands ne");
        @(negedge clk);
        chk("R8 idle after gap", {31'd0, res_valid}, 32'd0);
        chk("R9 no taken when idle", {31'd0, res_taken | res_illegal}, 32'd0);
        // R2, R3: sweep all codes over operand grid
        foreach (vals[i]) foreach (vals[j]) begin
            do_cmp(vals[i], vals[j]);
            for (int c = 0; c < 16; c++)
                do_br(4'(c), 10'h3F ^ 10'(c), 32'h1000 + 32'(c*4), 0, 0, 0, "R2 R3 sweep");
        end
        // R4: extreme offsets and wrap
        do_cmp(32'd3, 32'd3);
        do_br(4'd0, 10'h1FF, 32'hFFFF_FFF0, 0, 0, 0, "R4 max fwd wrap");
        do_br(4'd0, 10'h200, 32'h0000_0010, 0, 0, 0, "R4 max back wrap");
        do_br(4'd0, 10'h3FF, 32'h0000_0000, 0, 0, 0, "R4 minus one");
        do_br(4'd1, 10'h155, 32'hFFFF_FFFE, 0, 0, 0, "R5 fall wrap");
        // R6: illegal codes at arbitrary pc
        for (int c = 10; c < 16; c++)
            do_br(4'(c), 10'h2AA, 32'hDEAD_BEE0 + 32'(c), 0, 0, 0, "R6 illegal");
        // R7: compare and branch together use old operands
        do_cmp(32'd1, 32'd2);
        do_br(4'd4, 10'd8, 32'h2000, 1, 32'd9, 32'd2, "R7 same cycle old");
        do_br(4'd4, 10'd8, 32'h2000, 0, 0, 0, "R7 new operands after");
        do_br(4'd2, 10'd8, 32'h3000, 1, 32'h8000_0000, 32'd0, "R7 same cycle signed");
        do_br(4'd2, 10'd8, 32'h3000, 0, 0, 0, "R7 signed new");
        // R8: back-to-back branches, then gap
        do_br(4'd9, 10'd1, 32'h40, 0, 0, 0, "R8 back to back");
        @(negedge clk);
        chk("R8 valid drops", {31'd0, res_valid}, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule